// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a fast internal bus and a slower external memory port. It takes one write (address, data and byte lanes) into a single storage slot and then runs the external write cycle on its own. The internal bus does not have to wait for the external memory to finish, so it can serve other accesses in the meantime. The external side waits for a ready signal, so the memory can take any number of cycles.

The requester gets its acknowledge straight away when it owns the internal bus. When another master, such as a DMA engine, holds the bus, the write is still captured and sent out, but the acknowledge waits until ownership comes back. A second write that arrives while the slot is still draining is stalled. A read to external memory waits until any buffered write has completed, so memory operations stay in program order. Reads are acknowledged in the cycle the external memory reports ready, and that cycle also returns the read data.

Top module: `pwbuf`

## Requirements
- R1: During and after a synchronous active-high reset the slot is empty and `ext_req` is low. A write that is still pending when reset arrives is dropped.
- R2: If the slot is empty and `ib_own` is high, a write request (`ib_req`=1, `ib_we`=1) is acknowledged in the same cycle. The external write then begins on the next cycle with `ext_we`=1 and the captured address, data and byte lanes.
- R3: The acknowledge of a write does not wait for the external write to finish. It is given even when `ext_rdy` stays low for several cycles.
- R4: If `ib_own` is low when a write is requested, the write is still captured and driven to the external port. `ib_ack` stays low until the first cycle in which `ib_own` is high, and it is asserted in that cycle. The write is acknowledged only once.
- R5: A write request made while the slot is occupied is not acknowledged until the pending external write reports `ext_rdy`. It is accepted in the cycle after that ready.
- R6: A read request (`ib_req`=1, `ib_we`=0) made while a write is buffered issues no external read until that write has seen `ext_rdy`. The read cycle starts on the following cycle.
- R7: From the first cycle of an external cycle until `ext_rdy` is seen, `ext_addr`, `ext_we`, `ext_wdata` and `ext_be` stay unchanged.
- R8: A read is acknowledged in the cycle in which `ext_rdy` is high for its external cycle, and `ib_rdata` then equals `ext_rdata`.
- R9: An external read cycle drives `ext_we`=0 with all byte lanes of `ext_be` set. An external write cycle drives `ext_we`=1.
- R10: Each buffered write produces exactly one external cycle. If nothing else is waiting, `ext_req` is low in the cycle after the write's `ext_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ib_req | input | 1 | Internal-bus access request, held until acknowledged |
| ib_we | input | 1 | 1 = write, 0 = read |
| ib_addr | input | 32 | Internal-bus address |
| ib_wdata | input | 32 | Internal-bus write data |
| ib_be | input | 4 | Write byte lanes |
| ib_own | input | 1 | Requester currently owns the internal bus |
| ib_ack | output | 1 | Access acknowledge |
| ib_rdata | output | 32 | Read data, valid with a read acknowledge |
| ext_req | output | 1 | External cycle active |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | 32 | External address |
| ext_wdata | output | 32 | External write data |
| ext_be | output | 4 | External byte lanes |
| ext_rdy | input | 1 | External memory finished the current cycle |
| ext_rdata | input | 32 | External read data |

## Verification
The hardest case to reach is a write whose external cycle has already finished while the acknowledge is still held back because another master owns the internal bus. The requester keeps its request high the whole time, and that request must not be captured a second time. The bench produces this by keeping `ib_own` low for several cycles while its memory model answers with zero wait. It then checks that exactly one external cycle was seen and that exactly one acknowledge arrives, in the first cycle ownership returns. It also keeps a write draining against a slow memory model while it raises a second write and then a read, and checks the cycle in which each is let through.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int PWB_AW = 32;
    localparam int PWB_DW = 32;
    localparam int PWB_BW = PWB_DW / 8;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_WRITE = 2'd1,
        XS_READ  = 2'd2
    } xs_e;

    typedef struct packed {
        logic [PWB_AW-1:0] addr;
        logic [PWB_DW-1:0] data;
        logic [PWB_BW-1:0] be;
    } wr_ent_t;

    function automatic logic [PWB_BW-1:0] full_lanes();
        return '1;
    endfunction

endpackage

// File: rtl/pwb_slot.sv
module pwb_slot
    import pwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  wr_ent_t din,
    output wr_ent_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/pwb_ackgen.sv
module pwb_ackgen (
    input  logic clk,
    input  logic rst,
    input  logic wr_take,
    input  logic own,
    output logic ack_wr,
    output logic pend
);

    // Acknowledge now if the bus is owned, otherwise remember the debt.
    assign ack_wr = own & (wr_take | pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (wr_take && !own) begin
            pend <= 1'b1;
        end else if (pend && own) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/pwb_xseq.sv
module pwb_xseq
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [PWB_AW-1:0] rd_addr,
    input  logic              rdy,
    output xs_e               state,
    output logic [PWB_AW-1:0] rd_addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= XS_IDLE;
            rd_addr_q <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (start_wr) begin
                        state <= XS_WRITE;
                    end else if (start_rd) begin
                        state     <= XS_READ;
                        rd_addr_q <= rd_addr;
                    end
                end
                XS_WRITE, XS_READ: begin
                    if (rdy) state <= XS_IDLE;
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwbuf.sv
module pwbuf
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ib_req,
    input  logic              ib_we,
    input  logic [PWB_AW-1:0] ib_addr,
    input  logic [PWB_DW-1:0] ib_wdata,
    input  logic [PWB_BW-1:0] ib_be,
    input  logic              ib_own,
    output logic              ib_ack,
    output logic [PWB_DW-1:0] ib_rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [PWB_AW-1:0] ext_addr,
    output logic [PWB_DW-1:0] ext_wdata,
    output logic [PWB_BW-1:0] ext_be,
    input  logic              ext_rdy,
    input  logic [PWB_DW-1:0] ext_rdata
);

    xs_e               xs;
    wr_ent_t           slot_q;
    wr_ent_t           slot_d;
    logic [PWB_AW-1:0] rd_addr_q;
    logic              pend;
    logic              ack_wr;
    logic              idle;
    logic              wr_take;
    logic              rd_take;

    // New work is taken only with the port idle and no acknowledge owed.
    assign idle    = (xs == XS_IDLE) && !pend;
    assign wr_take = ib_req &&  ib_we && idle;
    assign rd_take = ib_req && !ib_we && idle;

    assign slot_d = '{addr: ib_addr, data: ib_wdata, be: ib_be};

    pwb_slot u_slot (
        .clk  (clk),
        .rst  (rst),
        .load (wr_take),
        .din  (slot_d),
        .q    (slot_q)
    );

    pwb_ackgen u_ack (
        .clk     (clk),
        .rst     (rst),
        .wr_take (wr_take),
        .own     (ib_own),
        .ack_wr  (ack_wr),
        .pend    (pend)
    );

    pwb_xseq u_xseq (
        .clk       (clk),
        .rst       (rst),
        .start_wr  (wr_take),
        .start_rd  (rd_take),
        .rd_addr   (ib_addr),
        .rdy       (ext_rdy),
        .state     (xs),
        .rd_addr_q (rd_addr_q)
    );

    always_comb begin
        ext_req   = (xs != XS_IDLE);
        ext_we    = (xs == XS_WRITE);
        ext_addr  = (xs == XS_WRITE) ? slot_q.addr : rd_addr_q;
        ext_wdata = (xs == XS_WRITE) ? slot_q.data : '0;
        ext_be    = (xs == XS_WRITE) ? slot_q.be   : full_lanes();
        ib_ack    = ack_wr || ((xs == XS_READ) && ext_rdy);
        ib_rdata  = (xs == XS_READ) ? ext_rdata : '0;
    end

endmodule

// File: rtl/pwbuf_chk.sv
module pwbuf_chk
    import pwb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ib_we,
    input logic              ib_own,
    input logic              ib_ack,
    input logic [PWB_DW-1:0] ib_rdata,
    input logic              ext_req,
    input logic              ext_we,
    input logic [PWB_AW-1:0] ext_addr,
    input logic [PWB_DW-1:0] ext_wdata,
    input logic [PWB_BW-1:0] ext_be,
    input logic              ext_rdy,
    input logic [PWB_DW-1:0] ext_rdata
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !ext_req); // R1

    AST_WR_ACK_OWNED: assert property (@(posedge clk) disable iff (rst)
        (ib_ack && ib_we) |-> ib_own); // R4

    AST_WR_HOLDS_PORT: assert property (@(posedge clk) disable iff (rst)
        (ext_req && ext_we && !ext_rdy) |=> (ext_req && ext_we)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_rdy) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                                   && $stable(ext_wdata) && $stable(ext_be))); // R7

    AST_RD_RETURN: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_we && ext_rdy) |-> (ib_ack && ib_rdata == ext_rdata)); // R8

    AST_RD_LANES: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_we) |-> (ext_be == full_lanes())); // R9

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ext_req && ext_we && ext_rdy) |=> !ext_req); // R10

endmodule

bind pwbuf pwbuf_chk u_chk (.*);

// File: tb/pwbuf_bench.sv
module pwbuf_bench;
    import pwb_pkg::*;

    localparam time TCLK = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ib_req = 0, ib_we = 0, ib_own = 1;
    logic [31:0] ib_addr = '0, ib_wdata = '0;
    logic [3:0]  ib_be = '0;
    logic ib_ack, ext_req, ext_we;
    logic [31:0] ib_rdata, ext_addr, ext_wdata, ext_rdata;
    logic [3:0]  ext_be;
    logic ext_rdy = 1'b0;

    int checks = 0, fails = 0;
    int rdy_lat = 0, cnt = 0, n_done = 0;
    logic unstable = 0;
    logic [31:0] s_addr, s_data;
    logic [3:0]  s_be;
    logic        s_we;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [3:0]  log_be   [64];
    logic        log_we   [64];

    always #(TCLK/2) clk = ~clk;

    assign ext_rdata = ext_addr ^ 32'hC3A5_0F1E;

    pwbuf u_pwbuf (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // External memory model: ready after rdy_lat wait cycles, logs each cycle.
    always @(negedge clk) begin
        if (ext_req && !rst) begin
            if (cnt == 0) begin
                s_addr = ext_addr; s_data = ext_wdata; s_be = ext_be; s_we = ext_we;
                unstable = 0;
            end else if (s_addr !== ext_addr || s_data !== ext_wdata ||
                         s_be !== ext_be || s_we !== ext_we) begin
                unstable = 1;
            end
            if (cnt >= rdy_lat) begin
                ext_rdy = 1'b1;
                chk("R7", {31'b0, unstable}, 32'd0);
                log_addr[n_done[5:0]] = ext_addr;
                log_data[n_done[5:0]] = ext_wdata;
                log_be[n_done[5:0]]   = ext_be;
                log_we[n_done[5:0]]   = ext_we;
                n_done++;
                cnt = 0;
            end else begin
                ext_rdy = 1'b0;
                cnt++;
            end
        end else begin
            ext_rdy = 1'b0;
            cnt = 0;
        end
    end

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        logic [3:0]  ol;
        logic [3:0]  rl;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{32'h1000_0000, 32'hDEAD_BEEF, 4'hF, 4'd0, 4'd0},
        '{32'h1000_0004, 32'h0123_4567, 4'h3, 4'd0, 4'd5},
        '{32'h2000_0010, 32'hA5A5_5A5A, 4'h8, 4'd2, 4'd3},
        '{32'h2000_0020, 32'hFFFF_0000, 4'h1, 4'd6, 4'd0},
        '{32'h3000_0100, 32'h7E57_C0DE, 4'hC, 4'd1, 4'd7},
        '{32'h3FFF_FFFC, 32'h0000_0001, 4'h6, 4'd3, 4'd3}
    };

    task automatic do_wr(input vec_t v);
        int n0 = n_done, nd_ack = -1, ack_at = -1, guard = 0;
        rdy_lat = int'(v.rl);
        @(negedge clk);
        ib_req = 1; ib_we = 1; ib_addr = v.a; ib_wdata = v.d; ib_be = v.be;
        for (int k = 0; k <= int'(v.ol); k++) begin
            if (k > 0) @(negedge clk);
            ib_own = (k == int'(v.ol));
            #1;
            if (ib_ack) begin
                if (ack_at < 0) begin ack_at = k; nd_ack = n_done; end
                else ack_at = 99;
            end
        end
        chk(v.ol == 0 ? "R2 ack cycle" : "R4 ack cycle", 32'(ack_at), 32'(v.ol));
        if (v.ol == 0 && v.rl > 0) chk("R3 ack before ready", 32'(nd_ack), 32'(n0));
        @(negedge clk);
        ib_req = 0; ib_we = 0;
        #1;
        while (n_done == n0 && guard < 50) begin @(negedge clk); #1; guard++; end
        chk("R2 ext addr", log_addr[n0[5:0]], v.a);
        chk("R2 ext data", log_data[n0[5:0]], v.d);
        chk("R2 ext be",   {28'b0, log_be[n0[5:0]]}, {28'b0, v.be});
        chk("R9 ext we",   {31'b0, log_we[n0[5:0]]}, 32'd1);
        @(negedge clk); #1;
        chk("R10 single cycle", {31'b0, ext_req}, 32'd0);
        chk("R10 count", 32'(n_done), 32'(n0 + 1));
    endtask

    initial begin
        #(TCLK * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n0, cA, cB, cR, guard;
        logic [31:0] rd_got;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ext_req in reset", {31'b0, ext_req}, 32'd0);
        rst = 0;
        @(negedge clk); #1;
        chk("R1 ext_req after reset", {31'b0, ext_req}, 32'd0);
        chk("R1 ack after reset", {31'b0, ib_ack}, 32'd0);

        foreach (VT[i]) do_wr(VT[i]);

        // R5: second write while the slot drains.
        rdy_lat = 4; n0 = n_done; cA = -1; cB = -1;
        @(negedge clk);
        ib_req = 1; ib_we = 1; ib_own = 1;
        ib_addr = 32'h4000_0000; ib_wdata = 32'h1111_2222; ib_be = 4'hF;
        @(negedge clk);
        ib_addr = 32'h4000_0008; ib_wdata = 32'h3333_4444; ib_be = 4'h5;
        for (int c = 1; c < 30; c++) begin
            if (c > 1) @(negedge clk);
            #1;
            if (cA < 0 && n_done != n0) cA = c;
            if (ib_ack) begin cB = c; break; end
        end
        chk("R5 stall until ready", 32'(cB), 32'(cA + 1));
        @(negedge clk);
        ib_req = 0; ib_we = 0;
        guard = 0;
        while (n_done < n0 + 2 && guard < 50) begin @(negedge clk); guard++; end
        chk("R5 second write data", log_data[6'(n0 + 1)], 32'h3333_4444);

        // R6 and R8: read behind a buffered write.
        rdy_lat = 3; n0 = n_done; cR = -1; rd_got = '0;
        @(negedge clk);
        ib_req = 1; ib_we = 1; ib_addr = 32'h5000_0040; ib_wdata = 32'hCAFE_F00D; ib_be = 4'hF;
        @(negedge clk);
        ib_we = 0; ib_addr = 32'h5000_0040;
        for (int c = 1; c < 40; c++) begin
            if (c > 1) @(negedge clk);
            #1;
            if (ext_req && !ext_we && n_done == n0)
                chk("R6 read before write drained", 32'd1, 32'd0);
            if (ib_ack) begin cR = n_done; rd_got = ib_rdata; break; end
        end
        chk("R6 write first", {31'b0, log_we[n0[5:0]]}, 32'd1);
        chk("R6 read second", {31'b0, log_we[6'(n0 + 1)]}, 32'd0);
        chk("R9 read lanes", {28'b0, log_be[6'(n0 + 1)]}, 32'hF);
        chk("R8 ack at ready", 32'(cR), 32'(n0 + 2));
        chk("R8 read data", rd_got, 32'h5000_0040 ^ 32'hC3A5_0F1E);
        @(negedge clk);
        ib_req = 0;

        // R8: read from an idle buffer with a zero-wait memory.
        rdy_lat = 0; n0 = n_done;
        @(negedge clk);
        ib_req = 1; ib_we = 0; ib_addr = 32'h6000_0004;
        #1;
        chk("R8 no ack before cycle", {31'b0, ib_ack}, 32'd0);
        @(negedge clk); #1;
        chk("R8 idle read ack", {31'b0, ib_ack}, 32'd1);
        chk("R8 idle read data", ib_rdata, 32'h6000_0004 ^ 32'hC3A5_0F1E);
        @(negedge clk);
        ib_req = 0;

        // R1: reset drops a write still waiting on a slow memory.
        rdy_lat = 10;
        @(negedge clk);
        ib_req = 1; ib_we = 1; ib_own = 1; ib_addr = 32'h7000_0000;
        @(negedge clk);
        ib_req = 0; ib_we = 0;
        #1;
        chk("R1 write in flight", {31'b0, ext_req}, 32'd1);
        rst = 1;
        @(negedge clk); #1;
        chk("R1 reset drops write", {31'b0, ext_req}, 32'd0);
        rst = 0;
        @(negedge clk); #1;
        chk("R1 idle after reset", {31'b0, ext_req}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule